// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives the system reset of a microcontroller from three sources. The first is a power-on stretcher. The second is a digital low-supply flag. The third is a watchdog timer. Reset is held while the raw power-good bit is low or the low-supply flag is high. It is released only after the supply has been good without a break for a fixed hold period. Analog sensing is outside the block, so the comparator arrives as a single bit.

The watchdog restarts on either of two events. One is a falling edge on a dedicated kick input. The other is a falling edge on the serial-bus chip select. Both inputs pass through a two-flop synchroniser before edge detection. If chip select sits high or sits low for the whole interval, the watchdog expires, just as it does when software stops kicking. A watchdog expiry drives reset for the same hold period as a supply event.

A volatile cause bit records that the latest reset came from the watchdog. A supply event clears it, and so does a host clear strobe.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `sys_rst` is 1, `sys_rst_n` is 0 and `wd_cause` is 0.
- R2: While `pwr_good` is 0, `sys_rst` stays 1. Once `pwr_good` is 1 and `low_supply` is 0, `sys_rst` falls on exactly the HOLD_CYC-th rising clock edge after that, if the supply stays good.
- R3: `low_supply` at 1 (or `pwr_good` at 0) sets `sys_rst` at the next clock edge and restarts the hold count. A one-cycle glitch during the hold period therefore delays release to HOLD_CYC edges after the glitch ends.
- R4: `wd_sel` selects the timeout: 2'b00 gives TO_SHORT_CYC cycles, 2'b01 gives TO_MID_CYC and 2'b10 gives TO_LONG_CYC. With the watchdog enabled and no restart, `sys_rst` rises on exactly that edge counted from the release edge.
- R5: With `wd_sel` = 2'b11 or `wd_en` = 0, the watchdog never asserts reset.
- R6: A high-to-low change on `wd_kick` restarts the count. Because of two synchroniser flops and one edge flop, with no further restart, reset rises TO+3 edges after the first edge that samples the low level.
- R7: A falling edge on `spi_cs` restarts the count with the same latency as R6. `spi_cs` held high or held low throughout does not restart it.
- R8: A watchdog expiry holds `sys_rst` high for exactly HOLD_CYC edges.
- R9: `wd_cause` goes to 1 on the same edge at which a watchdog expiry raises `sys_rst`. It goes to 0 on the edge after `low_supply` is 1 or `pwr_good` is 0.
- R10: `flag_clr` clears `wd_cause` on the next edge. An expiry in the same cycle takes priority over the clear.
- R11: `sys_rst_n` is the inverse of `sys_rst`, and both change on the same edge.
- R12: The watchdog count is held at zero while `sys_rst` is 1. Each release therefore starts a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| pwr_good | input | 1 | Raw power-good bit, 1 = supply present |
| low_supply | input | 1 | Undervoltage comparator, 1 = supply below trip point |
| wd_kick | input | 1 | Watchdog kick, restarts on falling edge |
| spi_cs | input | 1 | Serial-bus chip select, restarts on falling edge |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Timeout select (00 short, 01 mid, 10 long, 11 off) |
| flag_clr | input | 1 | Host strobe clearing the watchdog cause bit |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_cause | output | 1 | 1 = latest reset came from the watchdog |

## Verification
Several properties are checked on every cycle. The two reset outputs always disagree. A supply drop or an expiry is always followed by reset. Release only happens after a good supply. The watchdog count is zero in the cycle after reset or after a restart. The cause bit follows its set and clear rules. Only the bench scenarios can show the exact interval lengths: the hold period, each of the three timeouts, the three-edge restart latency through the synchroniser, and the absence of expiry for stuck or disabled configurations. All of these depend on counting whole windows of cycles.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

    typedef enum logic {
        SUP_RUN  = 1'b0,
        SUP_HELD = 1'b1
    } sup_state_e;

    typedef struct packed {
        logic kick;
        logic cs;
    } wd_restart_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES+1:0] chain;

    assign chain[0] = din;

    for (genvar i = 1; i <= STAGES + 1; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b1;
            else     chain[i] <= chain[i-1];
        end
    end

    // older sample high, newer sample low
    assign fall = chain[STAGES+1] & ~chain[STAGES];

endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import sup_pkg::*;
#(
    parameter int HOLD_CYC = 20,
    parameter int HW       = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic trip,
    output logic rst_hi,
    output logic rst_lo
);
    sup_state_e    state;
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SUP_HELD;
            rst_lo <= 1'b0;
            cnt    <= '0;
        end else if (!supply_ok || trip) begin
            state  <= SUP_HELD;
            rst_lo <= 1'b0;
            cnt    <= '0;
        end else if (state == SUP_HELD) begin
            if (cnt == HW'(HOLD_CYC - 1)) begin
                state  <= SUP_RUN;
                rst_lo <= 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rst_hi = (state == SUP_HELD);

    assert_rst_pair_R11: assert property (@(posedge clk) disable iff (rst)
        rst_hi != rst_lo);
    assert_supply_drop_R3: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> rst_hi);
    assert_trip_holds_R8: assert property (@(posedge clk) disable iff (rst)
        trip |=> rst_hi);
    assert_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hi) |-> $past(supply_ok));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import sup_pkg::*;
#(
    parameter int TO_SHORT_CYC = 40,
    parameter int TO_MID_CYC   = 80,
    parameter int TO_LONG_CYC  = 120,
    parameter int CW           = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sys_rst,
    input  logic        wd_en,
    input  wd_sel_e     sel,
    input  wd_restart_t restart,
    output logic        trip
);
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt;
    logic          active;
    logic          kicked;

    always_comb begin
        case (sel)
            WD_SEL_SHORT: limit = CW'(TO_SHORT_CYC);
            WD_SEL_MID:   limit = CW'(TO_MID_CYC);
            WD_SEL_LONG:  limit = CW'(TO_LONG_CYC);
            default:      limit = '0;
        endcase
    end

    assign active = wd_en && (sel != WD_SEL_OFF);
    assign kicked = restart.kick | restart.cs;
    assign trip   = active && !sys_rst && !kicked && (cnt >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || sys_rst || !active || kicked || trip) cnt <= '0;
        else                                             cnt <= cnt + 1'b1;
    end

    assert_hold_zero_R12: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> (cnt == '0));
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (kicked && !sys_rst) |=> (cnt == '0));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import sup_pkg::*;
#(
    parameter int HOLD_CYC     = 200_000,
    parameter int TO_SHORT_CYC = 600_000,
    parameter int TO_MID_CYC   = 1_400_000,
    parameter int TO_LONG_CYC  = 2_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       low_supply,
    input  logic       wd_kick,
    input  logic       spi_cs,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       flag_clr,
    output logic       sys_rst,
    output logic       sys_rst_n,
    output logic       wd_cause
);
    localparam int MAX_TO = int'(max3(TO_SHORT_CYC, TO_MID_CYC, TO_LONG_CYC));
    localparam int CW     = $clog2(MAX_TO + 1);
    localparam int HW     = $clog2(HOLD_CYC + 1);

    wd_restart_t restart;
    wd_sel_e     sel_e;
    logic        supply_ok;
    logic        trip;

    assign supply_ok = pwr_good & ~low_supply;
    assign sel_e     = wd_sel_e'(wd_sel);

    edge_sync #(.STAGES(SYNC_STAGES)) u_kick_sync (
        .clk(clk), .rst(rst), .din(wd_kick), .fall(restart.kick)
    );
    edge_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
        .clk(clk), .rst(rst), .din(spi_cs), .fall(restart.cs)
    );

    wdog_timer #(
        .TO_SHORT_CYC(TO_SHORT_CYC), .TO_MID_CYC(TO_MID_CYC),
        .TO_LONG_CYC(TO_LONG_CYC), .CW(CW)
    ) u_wdog (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .wd_en(wd_en),
        .sel(sel_e), .restart(restart), .trip(trip)
    );

    hold_timer #(.HOLD_CYC(HOLD_CYC), .HW(HW)) u_hold (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .trip(trip),
        .rst_hi(sys_rst), .rst_lo(sys_rst_n)
    );

    // supply loss beats expiry, expiry beats host clear
    always_ff @(posedge clk) begin
        if (rst)             wd_cause <= 1'b0;
        else if (!supply_ok) wd_cause <= 1'b0;
        else if (trip)       wd_cause <= 1'b1;
        else if (flag_clr)   wd_cause <= 1'b0;
    end

    assert_cause_set_R9: assert property (@(posedge clk) disable iff (rst)
        (trip && supply_ok) |=> (wd_cause && sys_rst));
    assert_cause_lost_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !wd_cause);
    assert_cause_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !trip) |=> !wd_cause);

endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 20;
    localparam int T0 = 40;
    localparam int T1 = 80;
    localparam int T2 = 120;

    logic clk = 1'b0;
    logic rst, pwr_good, low_supply, wd_kick, spi_cs, wd_en, flag_clr;
    logic [1:0] wd_sel;
    logic sys_rst, sys_rst_n, wd_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rst_supervisor #(
        .HOLD_CYC(HOLD), .TO_SHORT_CYC(T0), .TO_MID_CYC(T1),
        .TO_LONG_CYC(T2), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .low_supply(low_supply),
        .wd_kick(wd_kick), .spi_cs(spi_cs), .wd_en(wd_en), .wd_sel(wd_sel),
        .flag_clr(flag_clr), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n),
        .wd_cause(wd_cause)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // mode: 0 idle, 1 kick pulses, 2 cs pulses, 3 cs held low
    typedef struct packed {
        logic [1:0] sel;
        logic       en;
        logic [1:0] mode;
        logic [7:0] period;
        logic [7:0] expn;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{2'd0, 1'b1, 2'd0, 8'd0,  8'd40},
        '{2'd1, 1'b1, 2'd0, 8'd0,  8'd80},
        '{2'd2, 1'b1, 2'd0, 8'd0,  8'd120},
        '{2'd3, 1'b1, 2'd0, 8'd0,  8'd0},
        '{2'd0, 1'b1, 2'd1, 8'd15, 8'd0},
        '{2'd0, 1'b1, 2'd2, 8'd15, 8'd0},
        '{2'd0, 1'b1, 2'd3, 8'd0,  8'd40},
        '{2'd1, 1'b0, 2'd0, 8'd0,  8'd0},
        '{2'd2, 1'b1, 2'd1, 8'd50, 8'd0},
        '{2'd0, 1'b1, 2'd1, 8'd60, 8'd40}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure_release(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1;
            n++;
            if (!sys_rst) break;
        end
    endtask

    task automatic resupply(input logic [1:0] sel, input logic en, input logic cs_lvl,
                            output int n);
        @(negedge clk);
        low_supply = 1'b1; wd_sel = sel; wd_en = en; wd_kick = 1'b1; spi_cs = cs_lvl;
        @(negedge clk);
        low_supply = 1'b0;
        measure_release(n);
    endtask

    task automatic run_wd(input int mode, input int period, input int once_at,
                          output int at);
        at = 0;
        for (int k = 1; k <= 200; k++) begin
            @(posedge clk); #1;
            if (sys_rst) begin at = k; break; end
            if (period > 0 && mode == 1) wd_kick = !(k >= period && (k % period) < 2);
            if (period > 0 && mode == 2) spi_cs  = !(k >= period && (k % period) < 2);
            if (once_at > 0 && k == once_at) begin
                if (mode == 1) wd_kick = 1'b0;
                if (mode == 2) spi_cs  = 1'b0;
            end
            if (once_at > 0 && k == once_at + 2) begin
                wd_kick = 1'b1;
                if (mode == 2) spi_cs = 1'b1;
            end
        end
        wd_kick = 1'b1;
        if (mode != 3) spi_cs = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int at;
        rst = 1'b1; pwr_good = 1'b0; low_supply = 1'b0; wd_kick = 1'b1; spi_cs = 1'b1;
        wd_en = 1'b1; wd_sel = 2'b00; flag_clr = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 sys_rst", int'(sys_rst), 1);
        chk("R1 sys_rst_n", int'(sys_rst_n), 0);
        chk("R1 wd_cause", int'(wd_cause), 0);
        @(negedge clk); rst = 1'b0;
        repeat (3 * HOLD) @(posedge clk);
        #1;
        chk("R2 held without power", int'(sys_rst), 1);
        @(negedge clk); pwr_good = 1'b1;
        measure_release(n);
        chk("R2 power-on hold", n, HOLD);
        chk("R11 inverse after release", int'(sys_rst_n), 1);

        // table walk: R4 R5 R6 R7 R12 under distinct patterns
        foreach (VECS[v]) begin
            resupply(VECS[v].sel, VECS[v].en, (VECS[v].mode == 2'd3) ? 1'b0 : 1'b1, n);
            chk($sformatf("R3 release hold vec%0d", v), n, HOLD);
            run_wd(int'(VECS[v].mode), int'(VECS[v].period), 0, at);
            chk($sformatf("R4 R5 R7 R12 expiry edge vec%0d", v), at, int'(VECS[v].expn));
            if (VECS[v].expn != 0) begin
                chk($sformatf("R9 cause set vec%0d", v), int'(wd_cause), 1);
                chk($sformatf("R11 inverse in reset vec%0d", v), int'(sys_rst_n), 0);
            end
        end

        // R6 single kick latency
        resupply(2'b00, 1'b1, 1'b1, n);
        run_wd(1, 0, 10, at);
        chk("R6 kick restart latency", at, 10 + T0 + 3);
        // R8 hold after expiry
        measure_release(n);
        chk("R8 watchdog reset length", n, HOLD);

        // R7 single cs edge latency
        resupply(2'b00, 1'b1, 1'b1, n);
        run_wd(2, 0, 10, at);
        chk("R7 cs restart latency", at, 10 + T0 + 3);
        chk("R9 cause after cs timeout", int'(wd_cause), 1);

        // R10 host clear
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
        chk("R10 clear cause", int'(wd_cause), 0);
        measure_release(n);

        // R10 expiry wins over a held clear
        flag_clr = 1'b1;
        run_wd(0, 0, 0, at);
        chk("R10 expiry edge with clear held", at, T0);
        chk("R10 expiry beats clear", int'(wd_cause), 1);
        @(posedge clk); #1;
        chk("R10 clear next edge", int'(wd_cause), 0);
        flag_clr = 1'b0;
        measure_release(n);

        // R9 low supply clears cause, R3 immediate reset
        run_wd(0, 0, 0, at);
        chk("R9 cause before supply drop", int'(wd_cause), 1);
        low_supply = 1'b1;
        @(posedge clk); #1;
        chk("R9 cause cleared by low supply", int'(wd_cause), 0);
        low_supply = 1'b0;
        measure_release(n);
        low_supply = 1'b1;
        @(posedge clk); #1;
        chk("R3 reset on low supply", int'(sys_rst), 1);
        chk("R11 inverse on low supply", int'(sys_rst_n), 0);
        low_supply = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        low_supply = 1'b1;
        @(posedge clk); #1;
        low_supply = 1'b0;
        measure_release(n);
        chk("R3 glitch restarts hold", n, HOLD);

        // R9 power loss clears cause
        run_wd(0, 0, 0, at);
        pwr_good = 1'b0;
        @(posedge clk); #1;
        chk("R9 cause cleared by power loss", int'(wd_cause), 0);
        chk("R2 reset on power loss", int'(sys_rst), 1);
        pwr_good = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule